// File: doc/BRIEF.md
# Two-Channel Droop-Correcting Half-Rate FIR

This block sits behind a multi-stage integrator-comb decimator. It accepts one stream that carries two interleaved channels and filters each channel with a 16-tap symmetric FIR. The FIR boosts the upper passband to undo the droop of a 4-stage, rate-4 integrator-comb section. The block also halves the sample rate of each channel. Each input beat is tagged with its channel by its packet markers. Each channel keeps its own history, and every second accepted sample of a channel starts the computation of one output for that channel.

To save area, the symmetric taps are folded by pre-adding mirrored samples. Four multipliers then work through the eight folded pairs over two clock cycles. The full-precision 32-bit result leaves on an output stream whose packet markers identify the channel.

Both stream edges use valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a computation is in progress. It is also low while a finished result is held because `out_ready` is low. A result stays on `out_data` with its markers unchanged until the edge where `out_valid` and `out_ready` are both high. Throughput is limited only by these two conditions. A nominal half-rate interleaved input therefore yields output on about a quarter of the cycles.

Top module: `cfir_decim2`

## Requirements
- R1: The input markers select the channel: `in_sop`=1 with `in_eop`=0 is channel 0, and `in_sop`=0 with `in_eop`=1 is channel 1. A beat that is accepted with both markers low or both high is discarded. It changes no history and no phase, and it produces no output.
- R2: Each channel keeps a separate 16-sample history. Samples of one channel never affect the results of the other channel.
- R3: A channel produces exactly one output for every two of its accepted samples, and the output is computed on the second of the pair. The output is y = sum over k=0..15 of c[k]·x[n−k], where x[n] is the newest sample of that channel. The coefficients are c[0..7] = −3, 8, −19, 37, −68, 122, −241, 1204 and c[15−k] = c[k].
- R4: Inputs are signed 16-bit two's complement. The output is the exact signed 32-bit sum, with no rounding or saturation, including for full-scale inputs.
- R5: While `out_valid` is high, exactly one of `out_sop` and `out_eop` is high: `out_sop` for a channel-0 result and `out_eop` for a channel-1 result.
- R6: `out_valid` rises on the second clock edge after the edge that accepts the triggering sample. `in_ready` is low in the two cycles between those edges.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values and `in_ready` is low.
- R8: Cycles with `in_valid` low change neither the histories nor the decimation phases.
- R9: Reset (asynchronous, active-low `rst_n`) clears both histories, both phases and the accumulator. After reset `out_valid` is 0 and `in_ready` is 1, and the next channel sample is the first of a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 16 | Signed input sample |
| in_sop | input | 1 | Channel-0 marker |
| in_eop | input | 1 | Channel-1 marker |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Signed full-precision result |
| out_sop | output | 1 | Result belongs to channel 0 |
| out_eop | output | 1 | Result belongs to channel 1 |

## Verification
The hardest case to reach from the ports is a mid-pair phase state that meets a disruption. The disruption can be a malformed-marker beat, a reset, or a held output. A wrong phase advance there shows up only as a result that arrives one sample early or late. The bench therefore drives odd numbers of samples into one channel before each disruption. It then uses an impulse or a pattern whose expected outputs differ from one sample position to the next, so any phase slip or leftover history shows in the value or in an output that should not appear. Back-pressure is reached by dropping `out_ready` just before a triggering sample.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  localparam int TAPS   = 16;
  localparam int HALF   = TAPS / 2;
  localparam int COEF_W = 12;
  localparam int IDX_W  = $clog2(TAPS);

  // Folded coefficient lookup: index k and TAPS-1-k share one value.
  function automatic logic signed [COEF_W-1:0] coef_at(input logic [IDX_W-1:0] k);
    logic [IDX_W-1:0] j;
    j = (k < IDX_W'(HALF)) ? k : IDX_W'(TAPS - 1) - k;
    case (j)
      4'd0:    return -12'sd3;
      4'd1:    return  12'sd8;
      4'd2:    return -12'sd19;
      4'd3:    return  12'sd37;
      4'd4:    return -12'sd68;
      4'd5:    return  12'sd122;
      4'd6:    return -12'sd241;
      default: return  12'sd1204;
    endcase
  endfunction

endpackage

// File: rtl/cfir_delay_bank.sv
module cfir_delay_bank #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  parameter int CHANS  = 2,
  parameter int CH_W   = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en,
  input  logic [CH_W-1:0]               shift_ch,
  input  logic [DATA_W-1:0]             din,
  input  logic [CH_W-1:0]               rd_ch,
  output logic [TAPS-1:0][DATA_W-1:0]   rd_line
);

  logic [TAPS-1:0][DATA_W-1:0] all_h [CHANS];

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    logic [TAPS-1:0][DATA_W-1:0] hist;

    // Element 0 holds the newest sample of this channel.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist <= '0;
      end else if (shift_en && shift_ch == CH_W'(c)) begin
        hist <= {hist[TAPS-2:0], din};
      end
    end

    assign all_h[c] = hist;
  end

  assign rd_line = all_h[rd_ch];

endmodule

// File: rtl/cfir_lane.sv
module cfir_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 12,
  parameter int ACC_W  = 32
) (
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  input  logic signed [COEF_W-1:0] coef,
  output logic [ACC_W-1:0]         prod
);

  logic signed [DATA_W:0]        pre;
  logic signed [DATA_W+COEF_W:0] mul;

  always_comb begin
    pre  = $signed({a[DATA_W-1], a}) + $signed({b[DATA_W-1], b});
    mul  = pre * coef;
    prod = ACC_W'(mul);
  end

endmodule

// File: rtl/cfir_mac_slice.sv
module cfir_mac_slice #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  parameter int MULTS  = 4,
  parameter int ACC_W  = 32,
  parameter int CYC_W  = 1
) (
  input  logic [TAPS-1:0][DATA_W-1:0] line,
  input  logic [CYC_W-1:0]            cyc,
  output logic signed [ACC_W-1:0]     part
);

  localparam int IDX_W  = cfir_pkg::IDX_W;
  localparam int COEF_W = cfir_pkg::COEF_W;

  logic [MULTS-1:0][ACC_W-1:0] prods;

  for (genvar m = 0; m < MULTS; m++) begin : g_lane
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;

    assign lo = IDX_W'(cyc) * IDX_W'(MULTS) + IDX_W'(m);
    assign hi = IDX_W'(TAPS - 1) - lo;

    cfir_lane #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) u_lane (
      .a   (line[lo]),
      .b   (line[hi]),
      .coef(cfir_pkg::coef_at(lo)),
      .prod(prods[m])
    );
  end

  always_comb begin
    part = '0;
    for (int m = 0; m < MULTS; m++) begin
      part = part + $signed(prods[m]);
    end
  end

endmodule

// File: rtl/cfir_ctrl.sv
module cfir_ctrl #(
  parameter int CHANS = 2,
  parameter int CH_W  = 1,
  parameter int NCYC  = 2,
  parameter int CYC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             tag_ok,
  input  logic [CH_W-1:0]  in_ch,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             shift_en,
  output logic             busy,
  output logic [CYC_W-1:0] cyc,
  output logic [CH_W-1:0]  work_ch
);

  logic [CHANS-1:0] phase;

  assign in_ready = !busy && slot_free;
  assign shift_en = in_valid && in_ready && tag_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      busy    <= 1'b0;
      cyc     <= '0;
      work_ch <= '0;
    end else if (shift_en) begin
      phase[in_ch] <= ~phase[in_ch];
      if (phase[in_ch]) begin
        busy    <= 1'b1;
        cyc     <= '0;
        work_ch <= in_ch;
      end
    end else if (busy) begin
      if (cyc == CYC_W'(NCYC - 1)) begin
        busy <= 1'b0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfir_decim2.sv
module cfir_decim2 #(
  parameter int DATA_W = 16,
  parameter int MULTS  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [DATA_W-1:0]                      in_data,
  input  logic                                   in_sop,
  input  logic                                   in_eop,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [DATA_W+cfir_pkg::COEF_W+cfir_pkg::IDX_W-1:0] out_data,
  output logic                                   out_sop,
  output logic                                   out_eop
);

  localparam int TAPS   = cfir_pkg::TAPS;
  localparam int COEF_W = cfir_pkg::COEF_W;
  localparam int ACC_W  = DATA_W + COEF_W + cfir_pkg::IDX_W;
  localparam int NCYC   = TAPS / (2 * MULTS);
  localparam int CYC_W  = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam int CHANS  = 2;
  localparam int CH_W   = 1;

  logic                        tag_ok;
  logic [CH_W-1:0]             in_ch;
  logic                        slot_free;
  logic                        shift_en;
  logic                        busy;
  logic [CYC_W-1:0]            cyc;
  logic [CH_W-1:0]             work_ch;
  logic [TAPS-1:0][DATA_W-1:0] rd_line;
  logic signed [ACC_W-1:0]     part;
  logic signed [ACC_W-1:0]     acc;
  logic signed [ACC_W-1:0]     base;
  logic signed [ACC_W-1:0]     sum_now;
  logic                        last;

  assign tag_ok    = in_sop ^ in_eop;
  assign in_ch     = in_eop;
  assign slot_free = !out_valid || out_ready;

  cfir_ctrl #(
    .CHANS(CHANS),
    .CH_W (CH_W),
    .NCYC (NCYC),
    .CYC_W(CYC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .tag_ok   (tag_ok),
    .in_ch    (in_ch),
    .slot_free(slot_free),
    .in_ready (in_ready),
    .shift_en (shift_en),
    .busy     (busy),
    .cyc      (cyc),
    .work_ch  (work_ch)
  );

  cfir_delay_bank #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS),
    .CHANS (CHANS),
    .CH_W  (CH_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .shift_ch(in_ch),
    .din     (in_data),
    .rd_ch   (work_ch),
    .rd_line (rd_line)
  );

  cfir_mac_slice #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS),
    .MULTS (MULTS),
    .ACC_W (ACC_W),
    .CYC_W (CYC_W)
  ) u_mac (
    .line(rd_line),
    .cyc (cyc),
    .part(part)
  );

  assign base    = (cyc == '0) ? '0 : acc;
  assign sum_now = base + part;
  assign last    = busy && (cyc == CYC_W'(NCYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else begin
      if (busy) begin
        acc <= sum_now;
      end
      if (last) begin
        out_valid <= 1'b1;
        out_data  <= sum_now;
        out_sop   <= (work_ch == 1'b0);
        out_eop   <= (work_ch == 1'b1);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfir_decim2_check.sv
module cfir_decim2_check #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sop,
  input logic             in_eop,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             busy
);

  assert_bad_tag_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(in_sop ^ in_eop) |=> !busy);

  assert_out_from_calc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));

  assert_one_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_sop, out_eop}));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  assert_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind cfir_decim2 cfir_decim2_check #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sop   (in_sop),
  .in_eop   (in_eop),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_sop  (out_sop),
  .out_eop  (out_eop),
  .busy     (busy)
);

// File: tb/cfir_decim2_test.sv
`timescale 1ns/1ps
module cfir_decim2_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        in_sop;
  logic        in_eop;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_sop;
  logic        out_eop;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R3";

  int hist [2][16];
  bit ph [2];
  int exp_val [$];
  bit exp_ch [$];
  int cf [16];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cfir_decim2 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < 2; c++) begin
      ph[c] = 0;
      for (int k = 0; k < 16; k++) hist[c][k] = 0;
    end
    exp_val.delete();
    exp_ch.delete();
  endfunction

  function automatic void model_accept(input int d, input bit s, input bit e);
    longint acc;
    int ch;
    if (s ^ e) begin
      ch = e ? 1 : 0;
      for (int k = 15; k > 0; k--) hist[ch][k] = hist[ch][k-1];
      hist[ch][0] = d;
      if (ph[ch]) begin
        acc = 0;
        for (int k = 0; k < 16; k++) acc += longint'(cf[k]) * longint'(hist[ch][k]);
        exp_val.push_back(int'(acc));
        exp_ch.push_back(e);
      end
      ph[ch] = !ph[ch];
    end
  endfunction

  // Output monitor: compares each transferred result with the model.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_val.size() == 0) begin
        check(0, cur_req, "unexpected output", longint'($signed(out_data)), 0);
      end else begin
        int ev;
        bit ec;
        ev = exp_val.pop_front();
        ec = exp_ch.pop_front();
        check($signed(out_data) == ev, cur_req, "out_data", longint'($signed(out_data)), ev);
        check(out_sop == !ec && out_eop == ec, "R5", "channel marker",
              {out_sop, out_eop}, {!ec, ec});
      end
    end
  end

  task automatic push(input int d, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d[15:0];
    in_sop   = s;
    in_eop   = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    model_accept(d, s, e);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ready(input bit r);
    @(posedge clk);
    #2;
    out_ready = r;
  endtask

  task automatic drain(input string req);
    idle(10);
    check(exp_val.size() == 0, req, "outputs still pending", exp_val.size(), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    cur_req = "R9";
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_impulse();
    cur_req = "R3";
    push(1000, 1, 0);
    push(0, 0, 1);
    for (int i = 0; i < 19; i++) begin
      push(0, 1, 0);
      push(0, 0, 1);
    end
    drain("R3");
  endtask

  task automatic t_isolation();
    cur_req = "R2";
    for (int i = 0; i < 24; i++) begin
      push(0, 1, 0);
      push(rnd16(), 0, 1);
    end
    drain("R2");
  endtask

  task automatic t_fullscale();
    cur_req = "R4";
    for (int i = 0; i < 20; i++) begin
      push(-32768, 1, 0);
      push((cf[i % 16] < 0) ? -32768 : 32767, 0, 1);
    end
    drain("R4");
  endtask

  task automatic t_latency();
    cur_req = "R6";
    if (ph[0]) push(rnd16(), 1, 0);
    drain("R6");
    push(rnd16(), 1, 0);
    push(rnd16(), 1, 0);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R6", "cycle 1 after trigger",
          {out_valid, in_ready}, 0);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R6", "cycle 2 after trigger",
          {out_valid, in_ready}, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "out_valid on second edge", out_valid, 1);
    drain("R6");
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    bit hs, he;
    cur_req = "R7";
    set_ready(0);
    push(rnd16(), 0, 1);
    if (!ph[1]) push(rnd16(), 0, 1);
    push(rnd16(), 0, 1);
    idle(3);
    check(out_valid == 1'b1, "R7", "result waiting", out_valid, 1);
    held = out_data;
    hs = out_sop;
    he = out_eop;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_data == held && out_sop == hs && out_eop == he, "R7", "held result",
            longint'($signed(out_data)), longint'($signed(held)));
      check(in_ready == 1'b0, "R7", "in_ready while held", in_ready, 0);
    end
    set_ready(1);
    drain("R7");
  endtask

  task automatic t_gaps();
    cur_req = "R8";
    for (int i = 0; i < 12; i++) begin
      push(rnd16(), 1, 0);
      idle(1 + (i % 4));
      push(rnd16(), 0, 1);
      idle(i % 3);
    end
    drain("R8");
  endtask

  task automatic t_bad_tag();
    cur_req = "R1";
    drain("R1");
    if (ph[0]) push(rnd16(), 1, 0);
    drain("R1");
    push(rnd16(), 1, 0);
    push(30000, 0, 0);
    push(-30000, 1, 1);
    idle(6);
    check(exp_val.size() == 0, "R1", "no output from bad markers", exp_val.size(), 0);
    for (int i = 0; i < 10; i++) begin
      push(rnd16(), 1, 0);
      push(12345, 1, 1);
      push(rnd16(), 0, 1);
      push(-777, 0, 0);
    end
    drain("R1");
  endtask

  task automatic t_reset_mid();
    cur_req = "R9";
    push(rnd16(), 1, 0);
    push(rnd16(), 1, 0);
    push(rnd16(), 1, 0);
    push(rnd16(), 0, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    idle(2);
    model_clear();
    rst_n = 1'b1;
    push(500, 1, 0);
    idle(4);
    check(exp_val.size() == 0, "R9", "phase cleared by reset", exp_val.size(), 0);
    for (int i = 0; i < 17; i++) push(0, 1, 0);
    drain("R9");
  endtask

  initial begin
    int half [8] = '{-3, 8, -19, 37, -68, 122, -241, 1204};
    for (int k = 0; k < 8; k++) begin
      cf[k] = half[k];
      cf[15-k] = half[k];
    end
    model_clear();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_sop = 1'b0;
    in_eop = 1'b0;
    out_ready = 1'b1;
    t_reset();
    t_impulse();
    t_isolation();
    t_fullscale();
    t_latency();
    t_backpressure();
    t_gaps();
    t_bad_tag();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule